// File: doc/BRIEF.md
# AES-128 Bidirectional Round Key Stepper

This block walks the AES-128 key expansion one round key per accepted step, holding only the current 128-bit round key. It can run forward from the cipher key toward the last round key, or backward from the last round key toward the cipher key. A cipher datapath that encrypts can run the schedule forward. A datapath that decrypts can load the final round key once and step backward, so no table of eleven round keys is needed.

The SubWord substitution is computed in the block from the GF(2^8) inverse and the affine map, through one four-lane S-box path shared by both directions. The round constant lives in its own register. That register is multiplied by x in GF(2^8) on a forward step and divided by x on a reverse step, so the direction can change between any two steps and the schedule stays consistent.

Top module: `aes_key_stepper`

## Requirements
- R1: While rst_ni is low, and after it, until the first load or step, rkey_o is all zeros and round_o is 0.
- R2: A cycle with load_i high makes rkey_o equal key_i in the next cycle. round_o then reads 0 if dir_rev_i was 0, or 10 if it was 1. load_i takes priority over step_i in the same cycle.
- R3: A forward step (step_i high, dir_rev_i 0) replaces the key words w0..w3 (w0 in bits 127:96). The new words are w0' = w0 ^ T, w1' = w1 ^ w0', w2' = w2 ^ w1' and w3' = w3 ^ w2'. T is the S-box applied to each byte of w3 rotated left by one byte, with the round constant XORed into its top byte. The result appears one cycle later.
- R4: A reverse step (step_i high, dir_rev_i 1) undoes one forward step and yields the previous round key. Ten reverse steps from the key 13111d7fe3944a17f307a78b4d2b30c5 return 000102030405060708090a0b0c0d0e0f.
- R5: A forward step while round_o is 10 changes neither rkey_o nor round_o.
- R6: A reverse step while round_o is 0 changes neither rkey_o nor round_o.
- R7: With load_i and step_i both low, rkey_o and round_o hold their values.
- R8: The round constant used to reach round n is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 (hex) for n = 1..10. Switching direction part-way through the schedule uses the constant matching the current round.
- R9: An accepted forward step increments round_o by 1, and an accepted reverse step decrements it by 1. round_o never exceeds 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load key_i and restart the round index for the selected direction |
| key_i | input | 128 | Key to load: the cipher key for forward, the last round key for reverse |
| step_i | input | 1 | Advance the schedule by one round |
| dir_rev_i | input | 1 | 0 selects forward, 1 selects reverse |
| rkey_o | output | 128 | Current round key |
| round_o | output | 4 | Index of the current round key, 0 to 10 |

## Verification
The hardest situation to reach is a direction change in the middle of the schedule. There the round constant register must already hold the value that belongs to the current round, even though no load has set it. The stimulus runs forward ten steps, then reverses without reloading and compares against the known round 9 key. It also takes three forward steps from a second cipher key, reverses once, and compares against that key's round 2 value. Saturation at both ends is reached by stepping past the last round and past the cipher key. Both events are followed by idle cycles that show the key held.

// File: rtl/aks_pkg.sv
package aks_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_WORDS = 4;
  localparam int unsigned KEY_W   = WORD_W * N_WORDS;
  localparam int unsigned BYTE_W  = 8;
  localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_inv_xtime(input logic [7:0] a);
    logic [7:0] t;
    t = a[0] ? (a ^ 8'h1b) : a;
    return {a[0], t[7:1]};
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = gf_xtime(x);
    end
    return p;
  endfunction

  // x^254 = x^-1, and 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq, acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 0; i < 7; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  // constant for stepping from round n-1 to round n, for n >= 1
  function automatic logic [7:0] rcon_of(input int unsigned n);
    logic [7:0] r;
    r = 8'h01;
    for (int unsigned i = 1; i < n; i++) r = gf_xtime(r);
    return r;
  endfunction
endpackage

// File: rtl/aks_sbox.sv
module aks_sbox (
  input  logic [7:0] a_i,
  output logic [7:0] s_o
);
  import aks_pkg::*;
  logic [7:0] inv;

  always_comb begin
    inv = gf_inv(a_i);
    for (int i = 0; i < 8; i++) begin
      s_o[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8] ^
               inv[(i + 6) % 8] ^ inv[(i + 7) % 8] ^ AFFINE_C[i];
    end
  end
endmodule

// File: rtl/aks_subword.sv
module aks_subword
  import aks_pkg::*;
(
  input  logic [WORD_W-1:0] w_i,
  output logic [WORD_W-1:0] w_o
);
  localparam int unsigned N_LANES = WORD_W / BYTE_W;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    aks_sbox u_sbox (
      .a_i(w_i[g*BYTE_W +: BYTE_W]),
      .s_o(w_o[g*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/aks_rcon_seq.sv
module aks_rcon_seq
  import aks_pkg::*;
#(
  parameter int unsigned LAST_ROUND = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic        rev_i,
  input  logic        adv_i,
  output logic [7:0]  rc_fwd_o,
  output logic [7:0]  rc_rev_o
);
  // register holds the constant for round index+1
  localparam logic [7:0] RC_FIRST = rcon_of(1);
  localparam logic [7:0] RC_PAST  = rcon_of(LAST_ROUND + 1);

  logic [7:0] rc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rc_q <= RC_FIRST;
    else if (load_i)  rc_q <= rev_i ? RC_PAST : RC_FIRST;
    else if (adv_i)   rc_q <= rev_i ? gf_inv_xtime(rc_q) : gf_xtime(rc_q);
  end

  assign rc_fwd_o = rc_q;
  assign rc_rev_o = gf_inv_xtime(rc_q);
endmodule

// File: rtl/aks_key_step.sv
module aks_key_step
  import aks_pkg::*;
(
  input  logic [KEY_W-1:0] key_i,
  input  logic             rev_i,
  input  logic [7:0]       rc_fwd_i,
  input  logic [7:0]       rc_rev_i,
  output logic [KEY_W-1:0] next_o
);
  logic [WORD_W-1:0] w [N_WORDS];
  logic [WORD_W-1:0] f [N_WORDS];
  logic [WORD_W-1:0] r [N_WORDS];
  logic [WORD_W-1:0] sw_in, sw_pre, sw_out, mix;
  logic [7:0]        rc;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_split
    assign w[g] = key_i[KEY_W-1-g*WORD_W -: WORD_W];
  end

  // undo the chain first: the last word recovers without the S-box
  assign r[3] = w[3] ^ w[2];
  assign r[2] = w[2] ^ w[1];
  assign r[1] = w[1] ^ w[0];

  assign sw_pre = rev_i ? r[3] : w[3];
  assign sw_in  = {sw_pre[WORD_W-9:0], sw_pre[WORD_W-1 -: 8]};
  assign rc     = rev_i ? rc_rev_i : rc_fwd_i;

  aks_subword u_subword (
    .w_i(sw_in),
    .w_o(sw_out)
  );

  assign mix  = sw_out ^ {rc, {(WORD_W-8){1'b0}}};
  assign r[0] = w[0] ^ mix;

  assign f[0] = w[0] ^ mix;
  for (genvar g = 1; g < N_WORDS; g++) begin : g_chain
    assign f[g] = w[g] ^ f[g-1];
  end

  always_comb begin
    for (int i = 0; i < N_WORDS; i++) begin
      next_o[KEY_W-1-i*WORD_W -: WORD_W] = rev_i ? r[i] : f[i];
    end
  end
endmodule

// File: rtl/aes_key_stepper.sv
module aes_key_stepper
  import aks_pkg::*;
#(
  parameter int unsigned LAST_ROUND = 10,
  parameter int unsigned ROUND_W    = $clog2(LAST_ROUND + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic               step_i,
  input  logic               dir_rev_i,
  output logic [KEY_W-1:0]   rkey_o,
  output logic [ROUND_W-1:0] round_o
);
  localparam logic [ROUND_W-1:0] R_LAST = ROUND_W'(LAST_ROUND);

  logic [KEY_W-1:0]   key_q, key_nxt;
  logic [ROUND_W-1:0] round_q;
  logic [7:0]         rc_fwd, rc_rev;
  logic               at_end, adv;

  assign at_end = dir_rev_i ? (round_q == '0) : (round_q == R_LAST);
  assign adv    = step_i && !load_i && !at_end;

  aks_rcon_seq #(.LAST_ROUND(LAST_ROUND)) u_rcon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .rev_i   (dir_rev_i),
    .adv_i   (adv),
    .rc_fwd_o(rc_fwd),
    .rc_rev_o(rc_rev)
  );

  aks_key_step u_step (
    .key_i   (key_q),
    .rev_i   (dir_rev_i),
    .rc_fwd_i(rc_fwd),
    .rc_rev_i(rc_rev),
    .next_o  (key_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      round_q <= '0;
    end else if (load_i) begin
      key_q   <= key_i;
      round_q <= dir_rev_i ? R_LAST : '0;
    end else if (adv) begin
      key_q   <= key_nxt;
      round_q <= dir_rev_i ? round_q - 1'b1 : round_q + 1'b1;
    end
  end

  assign rkey_o  = key_q;
  assign round_o = round_q;
endmodule

// File: rtl/aes_key_stepper_chk.sv
module aes_key_stepper_chk #(
  parameter int unsigned LAST_ROUND = 10,
  parameter int unsigned ROUND_W    = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic [127:0]       key_i,
  input logic               step_i,
  input logic               dir_rev_i,
  input logic [127:0]       rkey_o,
  input logic [ROUND_W-1:0] round_o
);
  localparam logic [ROUND_W-1:0] R_LAST = ROUND_W'(LAST_ROUND);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rkey_o == $past(key_i)) &&
               (round_o == ($past(dir_rev_i) ? R_LAST : '0)));

  p_fwd_chain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !dir_rev_i && round_o != R_LAST) |=>
      ((rkey_o[31:0] ^ rkey_o[63:32]) == $past(rkey_o[31:0])));

  p_rev_chain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && dir_rev_i && round_o != '0) |=>
      (rkey_o[31:0] == ($past(rkey_o[31:0]) ^ $past(rkey_o[63:32]))));

  p_fwd_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !dir_rev_i && round_o == R_LAST) |=>
      $stable(rkey_o) && round_o == R_LAST);

  p_rev_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && dir_rev_i && round_o == '0) |=>
      $stable(rkey_o) && round_o == '0);

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(rkey_o) && $stable(round_o));

  p_fwd_inc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !dir_rev_i && round_o != R_LAST) |=>
      round_o == $past(round_o) + 1'b1);

  p_rev_dec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && dir_rev_i && round_o != '0) |=>
      round_o == $past(round_o) - 1'b1);

  p_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_o <= R_LAST);
endmodule

bind aes_key_stepper aes_key_stepper_chk #(
  .LAST_ROUND(LAST_ROUND),
  .ROUND_W   (ROUND_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .key_i    (key_i),
  .step_i   (step_i),
  .dir_rev_i(dir_rev_i),
  .rkey_o   (rkey_o),
  .round_o  (round_o)
);

// File: tb/aes_key_stepper_tb.sv
module aes_key_stepper_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [127:0] key_i = '0;
  logic         step_i = 1'b0;
  logic         dir_rev_i = 1'b0;
  logic [127:0] rkey_o;
  logic [3:0]   round_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  localparam logic [127:0] K_A    = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] K_A_R1 = 128'hd6aa74fdd2af72fadaa678f1d6ab76fe;
  localparam logic [127:0] K_A_R9 = 128'h549932d1f08557681093ed9cbe2c974e;
  localparam logic [127:0] K_A_RX = 128'h13111d7fe3944a17f307a78b4d2b30c5;
  localparam logic [127:0] K_B    = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] K_B_R1 = 128'ha0fafe1788542cb123a339392a6c7605;
  localparam logic [127:0] K_B_R2 = 128'hf2c295f27a96b9435935807a7359f67f;
  localparam logic [127:0] K_B_R3 = 128'h3d80477d4716fe3e1e237e446d7a883b;
  localparam logic [127:0] K_B_RX = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

  always #2.5 clk_i = ~clk_i;

  aes_key_stepper u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .key_i    (key_i),
    .step_i   (step_i),
    .dir_rev_i(dir_rev_i),
    .rkey_o   (rkey_o),
    .round_o  (round_o)
  );

  task automatic check(input string tag, input logic [127:0] exp_k, input logic [3:0] exp_r);
    n_chk++;
    if (rkey_o !== exp_k || round_o !== exp_r) begin
      n_err++;
      $display("FAIL %s: key=%h round=%0d expected key=%h round=%0d",
               tag, rkey_o, round_o, exp_k, exp_r);
    end
  endtask

  task automatic do_load(input logic [127:0] k, input logic rev);
    @(negedge clk_i);
    load_i = 1'b1; key_i = k; dir_rev_i = rev;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic do_steps(input int n, input logic rev);
    @(negedge clk_i);
    step_i = 1'b1; dir_rev_i = rev;
    repeat (n) @(negedge clk_i);
    step_i = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    check("R1 in reset", '0, 4'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 after reset", '0, 4'd0);
  endtask

  task automatic t_forward_a;
    do_load(K_A, 1'b0);
    check("R2 forward load", K_A, 4'd0);
    do_steps(1, 1'b0);
    check("R3 R8 R9 round 1", K_A_R1, 4'd1);
    do_steps(9, 1'b0);
    check("R3 R8 R9 round 10", K_A_RX, 4'd10);
  endtask

  task automatic t_fwd_saturate;
    do_steps(3, 1'b0);
    check("R5 forward past last", K_A_RX, 4'd10);
  endtask

  task automatic t_switch_back;
    do_steps(1, 1'b1);
    check("R4 R8 reverse to round 9", K_A_R9, 4'd9);
    do_steps(9, 1'b1);
    check("R4 back to cipher key", K_A, 4'd0);
  endtask

  task automatic t_rev_saturate;
    do_steps(2, 1'b1);
    check("R6 reverse past start", K_A, 4'd0);
  endtask

  task automatic t_reverse_load;
    do_load(K_A_RX, 1'b1);
    check("R2 reverse load", K_A_RX, 4'd10);
    do_steps(10, 1'b1);
    check("R4 ten reverse steps", K_A, 4'd0);
  endtask

  task automatic t_second_key;
    do_load(K_B, 1'b0);
    do_steps(1, 1'b0);
    check("R3 second key round 1", K_B_R1, 4'd1);
    do_steps(2, 1'b0);
    check("R3 second key round 3", K_B_R3, 4'd3);
    do_steps(1, 1'b1);
    check("R8 switch at round 3", K_B_R2, 4'd2);
    do_steps(8, 1'b0);
    check("R8 resume forward to 10", K_B_RX, 4'd10);
    do_load(K_B_RX, 1'b1);
    do_steps(10, 1'b1);
    check("R4 second key back", K_B, 4'd0);
  endtask

  task automatic t_idle;
    do_load(K_B, 1'b0);
    do_steps(2, 1'b0);
    dir_rev_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R7 idle hold", K_B_R2, 4'd2);
  endtask

  task automatic t_load_priority;
    @(negedge clk_i);
    load_i = 1'b1; step_i = 1'b1; key_i = K_A; dir_rev_i = 1'b0;
    @(negedge clk_i);
    load_i = 1'b0; step_i = 1'b0;
    check("R2 load over step", K_A, 4'd0);
    do_steps(1, 1'b0);
    check("R2 R8 constant restarted", K_A_R1, 4'd1);
  endtask

  initial begin
    t_reset();
    t_forward_a();
    t_fwd_saturate();
    t_switch_back();
    t_rev_saturate();
    t_reverse_load();
    t_second_key();
    t_idle();
    t_load_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule